// File: doc/BRIEF.md
# Two-Thread Operating Mode Controller

This block tracks which hardware threads of a two-thread simultaneous multithreading core are running. It keeps one of four modes: dual-thread, thread 0 alone, thread 1 alone, or a low-power state in which both threads are halted. Each thread signals that it has executed HALT with a one-cycle pulse. An interrupt request to a thread wakes that thread.

From the current mode the block drives four outputs:
- a per-thread active vector;
- a recombine signal, which tells partitioned queues and buffers to hand all their entries to the single running thread;
- a low-power enable;
- the encoded mode.

The mode is held in a register. Every output changes on the clock edge that samples the HALT or interrupt event that caused the change.

The next mode is formed per thread and then encoded. A thread is running in the next cycle if it receives an interrupt. It is also running if it was already running and did not execute HALT. This single rule covers every transition, including the cases where both threads act in the same cycle.

Top module: `mt_mode_ctrl`

## Requirements
- R1: While `rst_n` is sampled low on a rising clock edge, the block enters dual-thread mode: both active bits are 1, recombine is 0 and low-power enable is 0.
- R2: `mode_o` encodes dual-thread as 2'b00, thread-0-only as 2'b01, thread-1-only as 2'b10 and low power as 2'b11. Bit t of `thread_active_o` is 1 exactly when thread t runs in the current mode.
- R3: In dual-thread mode, a HALT pulse from thread 1 alone moves the block to thread-0-only. A HALT pulse from thread 0 alone moves it to thread-1-only.
- R4: In dual-thread mode, HALT pulses from both threads in the same cycle move the block directly to low power.
- R5: In thread-0-only mode, a HALT from thread 0 moves the block to low power. In thread-1-only mode, a HALT from thread 1 does the same.
- R6: In low power, an interrupt to thread 0 alone leads to thread-0-only mode, an interrupt to thread 1 alone leads to thread-1-only mode, and interrupts to both in the same cycle lead to dual-thread mode.
- R7: In thread-0-only mode, an interrupt to thread 1 returns the block to dual-thread mode. In thread-1-only mode, an interrupt to thread 0 does the same.
- R8: When a thread receives an interrupt in the same cycle as its own HALT pulse, the interrupt wins and that thread is active in the next cycle.
- R9: A HALT pulse from a thread that is already halted has no effect, and so has an interrupt to a thread that is already running. The outputs then show the mode that the other thread's inputs alone select.
- R10: `recombine_o` is 1 exactly when one thread is active, that is, in thread-0-only and thread-1-only modes.
- R11: `lowpower_en_o` is 1 only in low-power mode, and only when no thread is active.
- R12: All outputs are registered. They change one cycle after the inputs that cause the change, and they hold their value in any cycle with no HALT pulse and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_i | input | 2 | Per-thread HALT-executed pulse, bit t for thread t |
| irq_i | input | 2 | Per-thread interrupt request, bit t for thread t |
| mode_o | output | 2 | Current mode, encoded as in R2 |
| thread_active_o | output | 2 | Per-thread running flag |
| recombine_o | output | 1 | Partitioned resources merge for the one running thread |
| lowpower_en_o | output | 1 | Core may enter its low-power condition |

## Verification
The assertions assume that `halt_i` and `irq_i` are sampled once per clock edge and treat each set bit as one event. They place no limit on which bits may be set together, so the properties also hold for a halted thread that pulses HALT, and for HALT and interrupt arriving together on the same thread. The stimulus relies on this freedom: a random phase drives every combination of the four input bits from every mode. Directed sequences first visit each transition of R3 to R8 on purpose, and reset is applied while HALT pulses are present.

// File: rtl/mt_mode_pkg.sv
// Package: shared mode type and constants for the two-thread mode controller.
// Assumes the core has exactly two hardware threads.
package mt_mode_pkg;
    localparam int THREADS = 2;
    localparam int MODE_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_MT  = 2'b00,
        MODE_ST0 = 2'b01,
        MODE_ST1 = 2'b10,
        MODE_LP  = 2'b11
    } mt_mode_e;
endpackage

// File: rtl/mt_thread_next.sv
// Module: next-cycle run flag for one hardware thread.
// An interrupt makes the thread run, and it wins over a HALT in the same cycle.
// A HALT stops a running thread. A halted thread with no interrupt stays halted.
// Assumes halt_i and irq_i are single-cycle event flags.
module mt_thread_next (
    input  logic active_i,
    input  logic halt_i,
    input  logic irq_i,
    output logic active_o
);
    // Purpose: choose the thread's run state for the next cycle.
    always_comb begin
        if (irq_i)
            active_o = 1'b1;
        else if (halt_i)
            active_o = 1'b0;
        else
            active_o = active_i;
    end
endmodule

// File: rtl/mt_mode_encode.sv
// Module: maps a per-thread run vector onto the encoded operating mode.
// Assumes bit t of the vector belongs to thread t.
module mt_mode_encode
    import mt_mode_pkg::*;
(
    input  logic [THREADS-1:0] run_i,
    output mt_mode_e           mode_o
);
    // Purpose: encode the run pattern as one of the four modes.
    always_comb begin
        unique case (run_i)
            2'b11:   mode_o = MODE_MT;
            2'b01:   mode_o = MODE_ST0;
            2'b10:   mode_o = MODE_ST1;
            default: mode_o = MODE_LP;
        endcase
    end
endmodule

// File: rtl/mt_mode_decode.sv
// Module: derives the per-thread flags, the recombine request and the
// low-power enable from the registered mode.
// Assumes the mode input comes from a register, so the outputs are glitch-free.
module mt_mode_decode
    import mt_mode_pkg::*;
(
    input  mt_mode_e           mode_i,
    output logic [THREADS-1:0] run_o,
    output logic               merge_o,
    output logic               sleep_o
);
    // Purpose: decode the mode into the status outputs.
    always_comb begin
        run_o   = '0;
        merge_o = 1'b0;
        sleep_o = 1'b0;
        case (mode_i)
            MODE_MT:  run_o = 2'b11;
            MODE_ST0: begin run_o = 2'b01; merge_o = 1'b1; end
            MODE_ST1: begin run_o = 2'b10; merge_o = 1'b1; end
            default:  sleep_o = 1'b1;
        endcase
    end

    // R11: low power never coexists with a running thread.
    always_comb begin
        assert_lp_idle_R11: assert (!(sleep_o && (run_o != '0)));
    end
endmodule

// File: rtl/mt_mode_ctrl.sv
// Module: operating mode controller for a two-thread SMT core.
// It holds the mode in a register and updates it from HALT pulses and
// interrupt requests. The outputs are decoded from the registered mode.
// Assumes a synchronous active-low reset and one event per bit per cycle.
module mt_mode_ctrl
    import mt_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [THREADS-1:0] halt_i,
    input  logic [THREADS-1:0] irq_i,
    output logic [MODE_W-1:0]  mode_o,
    output logic [THREADS-1:0] thread_active_o,
    output logic               recombine_o,
    output logic               lowpower_en_o
);
    mt_mode_e           mode_q;
    mt_mode_e           mode_d;
    logic [THREADS-1:0] run_now;
    logic [THREADS-1:0] run_next;

    mt_mode_decode u_decode (
        .mode_i  (mode_q),
        .run_o   (run_now),
        .merge_o (recombine_o),
        .sleep_o (lowpower_en_o)
    );

    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        mt_thread_next u_next (
            .active_i (run_now[t]),
            .halt_i   (halt_i[t]),
            .irq_i    (irq_i[t]),
            .active_o (run_next[t])
        );
    end

    mt_mode_encode u_encode (
        .run_i  (run_next),
        .mode_o (mode_d)
    );

    // Purpose: mode register, which enters dual-thread mode on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_MT;
        else
            mode_q <= mode_d;
    end

    assign mode_o          = mode_q;
    assign thread_active_o = run_now;

    // R1: a sampled reset leaves the block in dual-thread mode.
    assert_reset_mt_R1: assert property (@(posedge clk)
        !rst_n |=> (mode_o == MODE_MT && thread_active_o == 2'b11));

    // R3: thread 1 alone halting from dual-thread mode leaves thread 0 running.
    assert_mt_to_st0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_MT && halt_i == 2'b10 && irq_i == 2'b00)
        |=> (mode_o == MODE_ST0));

    // R4: a joint HALT from dual-thread mode goes straight to low power.
    assert_joint_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_MT && halt_i == 2'b11 && irq_i == 2'b00)
        |=> lowpower_en_o);

    // R8: an interrupt always leaves its thread running in the next cycle.
    assert_irq0_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i[0] |=> thread_active_o[0]);
    assert_irq1_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i[1] |=> thread_active_o[1]);

    // R9: a halted thread stays halted until it receives an interrupt.
    assert_halted_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!thread_active_o[0] && !irq_i[0]) |=> !thread_active_o[0]);

    // R10: recombine follows a single running thread.
    assert_recombine_R10: assert property (@(posedge clk) disable iff (!rst_n)
        recombine_o == ($countones(thread_active_o) == 1));

    // R12: with no events the mode holds.
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i == 2'b00 && irq_i == 2'b00) |=> $stable(mode_o));
endmodule

// File: tb/sim_mt_mode_ctrl.sv
// Bench: a behavioural model of the four modes is stepped on every clock,
// and all outputs are compared with it after each rising edge.
module sim_mt_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] halt_i = 2'b00;
    logic [1:0] irq_i = 2'b00;
    logic [1:0] mode_o;
    logic [1:0] thread_active_o;
    logic       recombine_o;
    logic       lowpower_en_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit finished = 0;
    int exp_mode = 0;   // 0 dual-thread, 1 thread 0 alone, 2 thread 1 alone, 3 low power

    mt_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .irq_i(irq_i),
        .mode_o(mode_o), .thread_active_o(thread_active_o),
        .recombine_o(recombine_o), .lowpower_en_o(lowpower_en_o)
    );

    always #5 clk = ~clk;

    // Next mode from a transition table written per current mode.
    function automatic int model_next(int m, logic [1:0] h, logic [1:0] q);
        bit r0, r1;
        case (m)
            0: begin r0 = q[0] || !h[0]; r1 = q[1] || !h[1]; end
            1: begin r0 = q[0] || !h[0]; r1 = q[1];          end
            2: begin r0 = q[0];          r1 = q[1] || !h[1]; end
            default: begin r0 = q[0];    r1 = q[1];          end
        endcase
        if (r0 && r1) return 0;
        if (r0)       return 1;
        if (r1)       return 2;
        return 3;
    endfunction

    task automatic check(string tag);
        logic [1:0] ea;
        ea = (exp_mode == 0) ? 2'b11 : (exp_mode == 1) ? 2'b01 :
             (exp_mode == 2) ? 2'b10 : 2'b00;
        compared++;
        if (mode_o !== exp_mode[1:0] || thread_active_o !== ea ||
            recombine_o !== (exp_mode == 1 || exp_mode == 2) ||
            lowpower_en_o !== (exp_mode == 3)) begin
            mismatched++;
            $display("FAIL %s: got mode=%b act=%b rec=%b lp=%b, expected mode=%0d act=%b rec=%0d lp=%0d",
                     tag, mode_o, thread_active_o, recombine_o, lowpower_en_o,
                     exp_mode, ea, (exp_mode == 1 || exp_mode == 2), (exp_mode == 3));
        end
    endtask

    // Drive one cycle of inputs, advance the model at the edge, then compare.
    task automatic step(logic [1:0] h, logic [1:0] q, string tag);
        halt_i = h;
        irq_i  = q;
        @(posedge clk);
        exp_mode = rst_n ? model_next(exp_mode, h, q) : 0;
        #2;
        check(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2'b11, 2'b00, "R1 reset with halts present");
        step(2'b01, 2'b00, "R1 reset held");
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        do_reset();
        step(2'b00, 2'b00, "R12 hold in MT");
        step(2'b10, 2'b00, "R3 MT halt1 to ST0");
        step(2'b00, 2'b00, "R12 hold in ST0 / R10");
        step(2'b00, 2'b01, "R9 irq to running thread0");
        step(2'b10, 2'b00, "R9 halt from halted thread1");
        step(2'b00, 2'b10, "R7 ST0 irq1 to MT");
        step(2'b01, 2'b00, "R3 MT halt0 to ST1");
        step(2'b00, 2'b01, "R7 ST1 irq0 to MT");
        step(2'b11, 2'b00, "R4 MT joint halt to LP");
        step(2'b00, 2'b00, "R11 hold in LP");
        step(2'b11, 2'b00, "R9 halts in LP ignored");
        step(2'b00, 2'b01, "R6 LP irq0 to ST0");
        step(2'b01, 2'b00, "R5 ST0 halt0 to LP");
        step(2'b00, 2'b10, "R6 LP irq1 to ST1");
        step(2'b10, 2'b00, "R5 ST1 halt1 to LP");
        step(2'b00, 2'b11, "R6 LP both irq to MT");
        step(2'b11, 2'b01, "R8 halt0 with irq0 to ST0");
        step(2'b01, 2'b10, "R8 ST0 halt0 irq1 to ST1");
        step(2'b10, 2'b10, "R8 ST1 halt1 with irq1 stays");
        do_reset();
        step(2'b11, 2'b00, "R4 joint halt after reset");
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] h, q;
            h = 2'($urandom_range(0, 3));
            q = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            step(h, q, "R2 R9 R12 random sequence");
        end
        finish_run();
    end
endmodule